// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block sends frames that software has described in a ring of 8-byte transmit descriptors held in memory. Each descriptor names one data buffer. A frame can span several buffers, and the buffer marked as final closes the frame. The engine starts on a one-cycle activation pulse, provided the controller enable input is high. It then walks the ring from its current descriptor pointer. For each descriptor it fetches the buffer with 32-bit word reads and streams the bytes out on a byte-wide valid/ready interface. It then writes the descriptor header back with the ready bit cleared and moves to the next descriptor, either the following slot or the ring start.

The walk ends at the first descriptor whose ready bit is clear. The pointer stays on that descriptor, so the next activation resumes there. A frame longer than 2032 bytes is cut at that size and a babbling-transmit event is raised. Three one-cycle event pulses report progress: buffer consumed, frame sent and babbling transmit. The frame-sent pulse comes with the frame's total byte count.

Top module: `tx_ring_engine`

## Requirements
- R1: A descriptor at address D is two big-endian words: the word at D holds flags in bits 31:16 and the buffer length in bytes in bits 15:0, and the word at D+4 holds the buffer byte address. In every memory word, the byte at the lowest address sits in bits 31:24. Every memory request uses a word-aligned address.
- R2: A `tx_kick` pulse while `ctl_en` is high starts a walk from the current descriptor pointer. A pulse while `ctl_en` is low is ignored: no memory request is issued and `busy` stays low.
- R3: When a fetched descriptor has flags bit 15 (ready) clear, the walk stops without writing that descriptor back, and the pointer stays on it. The next activation reads that same descriptor again.
- R4: Buffer bytes leave on `tx_tdata` in address order, buffer after buffer. `tx_tlast` is high on the final byte of each frame and on no other byte. Data and tlast hold steady while `tx_tvalid` is high and `tx_tready` is low.
- R5: After a buffer is consumed, the word at D is written back with flags bit 15 cleared and all other flag bits and the length unchanged. The buffer-address word is not written.
- R6: The next descriptor is the ring start address when flags bit 13 (wrap) is set, and D+8 otherwise.
- R7: A ring start write (`base_wr`) clears the low two address bits and also loads the current descriptor pointer.
- R8: `evt_txb` pulses once for each descriptor consumed. When a descriptor with flags bit 11 (last) is consumed, `evt_txf` pulses once and `frame_len` shows the number of bytes streamed in that frame.
- R9: Bytes that would take a frame past 2032 are dropped. Each descriptor whose length would cross that limit pulses `evt_babt`, and the frame reports a length of 2032.
- R10: A last descriptor of zero length ends the frame. `tx_tlast` is then placed on the final byte of the preceding buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Controller enable; gates activation |
| tx_kick | input | 1 | Transmit activation pulse |
| base_wr | input | 1 | Ring start address write strobe |
| base_wdata | input | AW | Ring start address value |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a word write |
| mem_addr | output | AW | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle, carries read data |
| mem_rdata | input | 32 | Read data |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tdata | output | 8 | Stream byte |
| tx_tlast | output | 1 | Final byte of frame |
| evt_txb | output | 1 | Descriptor consumed pulse |
| evt_txf | output | 1 | Frame sent pulse |
| evt_babt | output | 1 | Frame length limit exceeded pulse |
| frame_len | output | FLW | Length of last completed frame |
| busy | output | 1 | Ring walk in progress |

## Verification
The assertions take for granted that the memory acknowledges each request exactly once, for one cycle, and that `base_wr` is never raised during a walk. Only under these conditions can a pending request be expected to hold its address, and the pointer to be left alone by software. The bench memory model acknowledges one cycle after it sees a request and only when no acknowledge is already out. Ring start writes are issued only while `busy` is low. Backpressure is applied in a periodic pattern, so the assertion on data holding under stall is exercised mid-frame.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD_HDR, S_RD_PTR, S_FETCH, S_EMIT, S_WBACK, S_FLUSH, S_ADV
  } txr_state_e;

  localparam int FLG_READY = 15;
  localparam int FLG_WRAP  = 13;
  localparam int FLG_LAST  = 11;
  localparam int DESC_STEP = 8;
endpackage

// File: rtl/txr_len_clip.sv
`timescale 1ns/1ps
module txr_len_clip #(
  parameter int LEN_W = 16,
  parameter int FLW   = 11,
  parameter int CAP   = 2032
) (
  input  logic [FLW-1:0]   acc,
  input  logic [LEN_W-1:0] blen,
  output logic [LEN_W-1:0] eff,
  output logic             clipped
);
  localparam int SW = LEN_W + 1;
  logic [SW-1:0] sum;

  always_comb begin
    sum     = SW'(acc) + SW'(blen);
    clipped = (sum > SW'(CAP));
    eff     = clipped ? (LEN_W'(CAP) - LEN_W'(acc)) : blen;
  end
endmodule

// File: rtl/txr_ring_ptr.sv
`timescale 1ns/1ps
module txr_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] cur_q
);
  logic [AW-1:0] base_d, cur_d, aligned;

  always_comb begin
    aligned = base_in & {{(AW-2){1'b1}}, 2'b00};
    base_d  = base_q;
    cur_d   = cur_q;
    if (base_wr) begin
      base_d = aligned;
      cur_d  = aligned;
    end else if (adv) begin
      cur_d = wrap ? base_q : (cur_q + AW'(STEP));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
    end
  end
endmodule

// File: rtl/txr_byte_stage.sv
`timescale 1ns/1ps
module txr_byte_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       flush,
  output logic       can_push,
  input  logic       tready,
  output logic       tvalid,
  output logic [7:0] tdata,
  output logic       tlast
);
  logic       hold_vld, hold_vld_d;
  logic [7:0] hold_q, hold_d;
  logic       out_vld_d, out_last_d;
  logic [7:0] out_d;
  logic       out_free;

  always_comb begin
    out_free   = !tvalid || tready;
    can_push   = !hold_vld || out_free;
    hold_vld_d = hold_vld;
    hold_d     = hold_q;
    out_vld_d  = tvalid && !tready;
    out_d      = tdata;
    out_last_d = tlast;
    if (hold_vld && (push || flush)) begin
      out_vld_d  = 1'b1;
      out_d      = hold_q;
      out_last_d = flush;
    end
    if (push) begin
      hold_vld_d = 1'b1;
      hold_d     = push_data;
    end else if (flush) begin
      hold_vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_q   <= '0;
      tvalid   <= 1'b0;
      tdata    <= '0;
      tlast    <= 1'b0;
    end else begin
      hold_vld <= hold_vld_d;
      hold_q   <= hold_d;
      tvalid   <= out_vld_d;
      tdata    <= out_d;
      tlast    <= out_last_d;
    end
  end
endmodule

// File: rtl/tx_ring_engine.sv
`timescale 1ns/1ps
module tx_ring_engine
  import txr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CAP = 2032,
  parameter int FLW = $clog2(CAP + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_en,
  input  logic           tx_kick,
  input  logic           base_wr,
  input  logic [AW-1:0]  base_wdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           tx_tvalid,
  input  logic           tx_tready,
  output logic [7:0]     tx_tdata,
  output logic           tx_tlast,
  output logic           evt_txb,
  output logic           evt_txf,
  output logic           evt_babt,
  output logic [FLW-1:0] frame_len,
  output logic           busy
);
  localparam int LEN_W = 16;

  txr_state_e       st_q, st_d;
  logic [LEN_W-1:0] flags_q, flags_d, blen_q, blen_d, rem_q, rem_d;
  logic [AW-1:0]    bptr_q, bptr_d;
  logic [31:0]      word_q, word_d;
  logic [FLW-1:0]   acc_q, acc_d, flen_d;
  logic             txb_d, txf_d, babt_d;
  logic [LEN_W-1:0] eff;
  logic             clipped, adv, push, flush, can_push;
  logic [7:0]       lane_byte;
  logic [AW-1:0]    base_q, cur_q;
  logic [LEN_W-1:0] flags_wb;

  txr_ring_ptr #(.AW(AW), .STEP(DESC_STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_in(base_wdata),
    .adv(adv), .wrap(flags_q[FLG_WRAP]), .base_q(base_q), .cur_q(cur_q)
  );

  txr_len_clip #(.LEN_W(LEN_W), .FLW(FLW), .CAP(CAP)) u_clip (
    .acc(acc_q), .blen(blen_q), .eff(eff), .clipped(clipped)
  );

  txr_byte_stage u_stage (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(lane_byte),
    .flush(flush), .can_push(can_push), .tready(tx_tready),
    .tvalid(tx_tvalid), .tdata(tx_tdata), .tlast(tx_tlast)
  );

  always_comb begin
    case (bptr_q[1:0])
      2'd0:    lane_byte = word_q[31:24];
      2'd1:    lane_byte = word_q[23:16];
      2'd2:    lane_byte = word_q[15:8];
      default: lane_byte = word_q[7:0];
    endcase
    flags_wb           = flags_q;
    flags_wb[FLG_READY] = 1'b0;
  end

  always_comb begin
    st_d = st_q;  flags_d = flags_q;  blen_d = blen_q;  rem_d = rem_q;
    bptr_d = bptr_q;  word_d = word_q;  acc_d = acc_q;  flen_d = frame_len;
    txb_d = 1'b0;  txf_d = 1'b0;  babt_d = 1'b0;
    adv = 1'b0;  push = 1'b0;  flush = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = cur_q;
    mem_wdata = {flags_wb, blen_q};
    case (st_q)
      S_IDLE: if (tx_kick && ctl_en) st_d = S_RD_HDR;
      S_RD_HDR: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          flags_d = mem_rdata[31:16];
          blen_d  = mem_rdata[15:0];
          st_d    = mem_rdata[16 + FLG_READY] ? S_RD_PTR : S_IDLE;
        end
      end
      S_RD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + AW'(4);
        if (mem_ack) begin
          bptr_d = mem_rdata[AW-1:0];
          rem_d  = eff;
          babt_d = clipped;
          acc_d  = acc_q + FLW'(eff);
          st_d   = (eff != '0) ? S_FETCH : S_WBACK;
        end
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = {bptr_q[AW-1:2], 2'b00};
        if (mem_ack) begin
          word_d = mem_rdata;
          st_d   = S_EMIT;
        end
      end
      S_EMIT: if (can_push) begin
        push   = 1'b1;
        bptr_d = bptr_q + AW'(1);
        rem_d  = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1))       st_d = S_WBACK;
        else if (bptr_q[1:0] == 2'd3) st_d = S_FETCH;
      end
      S_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          txb_d = 1'b1;
          st_d  = flags_q[FLG_LAST] ? S_FLUSH : S_ADV;
        end
      end
      S_FLUSH: if (can_push) begin
        flush  = 1'b1;
        txf_d  = 1'b1;
        flen_d = acc_q;
        acc_d  = '0;
        st_d   = S_ADV;
      end
      default: begin
        adv  = 1'b1;
        st_d = S_RD_HDR;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  flags_q <= '0;  blen_q <= '0;  rem_q <= '0;
      bptr_q <= '0;  word_q <= '0;  acc_q <= '0;  frame_len <= '0;
      evt_txb <= 1'b0;  evt_txf <= 1'b0;  evt_babt <= 1'b0;
    end else begin
      st_q <= st_d;  flags_q <= flags_d;  blen_q <= blen_d;  rem_q <= rem_d;
      bptr_q <= bptr_d;  word_q <= word_d;  acc_q <= acc_d;
      frame_len <= flen_d;
      evt_txb <= txb_d;  evt_txf <= txf_d;  evt_babt <= babt_d;
    end
  end

  assign busy = (st_q != S_IDLE);
endmodule

// File: rtl/txr_checks.sv
`timescale 1ns/1ps
module txr_checks #(
  parameter int AW  = 32,
  parameter int FLW = 11,
  parameter int CAP = 2032
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctl_en,
  input logic           tx_kick,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [31:0]    mem_wdata,
  input logic           mem_ack,
  input logic           tx_tvalid,
  input logic           tx_tready,
  input logic [7:0]     tx_tdata,
  input logic           tx_tlast,
  input logic           evt_txb,
  input logic           evt_txf,
  input logic           evt_babt,
  input logic [FLW-1:0] frame_len,
  input logic           busy
);
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(tx_kick && ctl_en) |=> !busy);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

  a_r5_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_txb, evt_txf, evt_babt}));

  a_r9_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    evt_txf |-> frame_len <= FLW'(CAP));
endmodule

bind tx_ring_engine txr_checks #(.AW(AW), .FLW(FLW), .CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .tx_kick(tx_kick),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .tx_tvalid(tx_tvalid),
  .tx_tready(tx_tready), .tx_tdata(tx_tdata), .tx_tlast(tx_tlast),
  .evt_txb(evt_txb), .evt_txf(evt_txf), .evt_babt(evt_babt),
  .frame_len(frame_len), .busy(busy)
);

// File: tb/sim_tx_ring_engine.sv
`timescale 1ns/1ps
module sim_tx_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_en = 1'b0, tx_kick = 1'b0, base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_tvalid, tx_tready = 1'b1, tx_tlast;
  logic [7:0]  tx_tdata;
  logic        evt_txb, evt_txf, evt_babt, busy;
  logic [10:0] frame_len;

  tx_ring_engine u0 (.*);

  always #10 clk = ~clk;

  logic [7:0] mem [0:4095];
  logic [7:0] rx_d [0:4095];
  logic       rx_l [0:4095];
  int rx_n = 0, n_txb = 0, n_txf = 0, n_babt = 0, req_cnt = 0, last_len = -1;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit bp = 1'b0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[11:0]]      = mem_wdata[31:24];
        mem[mem_addr[11:0] + 1]  = mem_wdata[23:16];
        mem[mem_addr[11:0] + 2]  = mem_wdata[15:8];
        mem[mem_addr[11:0] + 3]  = mem_wdata[7:0];
      end
      mem_rdata <= {mem[mem_addr[11:0]], mem[mem_addr[11:0] + 1],
                    mem[mem_addr[11:0] + 2], mem[mem_addr[11:0] + 3]};
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 tx_tready = bp ? ((cyc % 3) != 2) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (tx_tvalid && tx_tready) begin
      rx_d[rx_n] = tx_tdata;
      rx_l[rx_n] = tx_tlast;
      rx_n++;
    end
    if (evt_txb) n_txb++;
    if (evt_babt) n_babt++;
    if (evt_txf) begin n_txf++; last_len = int'(frame_len); end
    if (mem_req) req_cnt++;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
    finish_run();
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_word(input int a, input logic [31:0] w);
    mem[a] = w[31:24]; mem[a+1] = w[23:16]; mem[a+2] = w[15:8]; mem[a+3] = w[7:0];
  endtask

  function automatic int get_word(input int a);
    return int'({mem[a], mem[a+1], mem[a+2], mem[a+3]});
  endfunction

  task automatic put_desc(input int d, input logic [15:0] f, input logic [15:0] len,
                          input int ptr);
    put_word(d, {f, len});
    put_word(d + 4, 32'(ptr));
  endtask

  task automatic clear_obs();
    rx_n = 0; n_txb = 0; n_txf = 0; n_babt = 0; req_cnt = 0; last_len = -1;
  endtask

  task automatic kick_and_wait();
    @(posedge clk); #1 tx_kick = 1'b1;
    @(posedge clk); #1 tx_kick = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy && !tx_tvalid) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic write_base(input int v);
    @(posedge clk); #1 base_wr = 1'b1; base_wdata = 32'(v);
    @(posedge clk); #1 base_wr = 1'b0;
  endtask

  function automatic int seg_bad(input int idx, input int addr, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (rx_d[idx + k] !== pat(addr + k)) bad++;
    return bad;
  endfunction

  function automatic int last_count();
    int c = 0;
    for (int k = 0; k < rx_n; k++) if (rx_l[k]) c++;
    return c;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R2 reset busy", int'(busy), 0);
    chk("R4 reset tvalid", int'(tx_tvalid), 0);
    chk("R2 reset mem_req", int'(mem_req), 0);
  endtask

  task automatic t_disabled();
    clear_obs();
    ctl_en = 1'b0;
    put_desc(0, 16'h8800, 16'd5, 'h101);
    kick_and_wait();
    repeat (8) @(negedge clk);
    chk("R2 kick while disabled issues no request", req_cnt, 0);
    chk("R2 kick while disabled sends no byte", rx_n, 0);
  endtask

  task automatic t_single();
    clear_obs();
    ctl_en = 1'b1;
    put_desc(8, 16'h0000, 16'd0, 0);
    kick_and_wait();
    chk("R4 single frame byte count", rx_n, 5);
    chk("R4 single frame data", seg_bad(0, 'h101, 5), 0);
    chk("R4 tlast on fifth byte", int'(rx_l[4]), 1);
    chk("R4 one tlast", last_count(), 1);
    chk("R8 single txb", n_txb, 1);
    chk("R8 single txf", n_txf, 1);
    chk("R8 single frame_len", last_len, 5);
    chk("R5 writeback header", get_word(0), 32'h08000005);
    chk("R5 pointer word untouched", get_word(4), 'h101);
    chk("R1 stop descriptor not written", get_word(8), 0);
  endtask

  task automatic t_multi();
    clear_obs();
    bp = 1'b1;
    put_desc(8,  16'h8000, 16'd6, 'h203);
    put_desc(16, 16'h8000, 16'd7, 'h30A);
    put_desc(24, 16'h8800, 16'd0, 0);
    put_desc(32, 16'h2800, 16'd2, 'h400);
    kick_and_wait();
    bp = 1'b0;
    chk("R3 resume at kept pointer, byte count", rx_n, 13);
    chk("R4 first buffer data", seg_bad(0, 'h203, 6), 0);
    chk("R4 second buffer data under backpressure", seg_bad(6, 'h30A, 7), 0);
    chk("R10 tlast on byte 13", int'(rx_l[12]), 1);
    chk("R10 one tlast", last_count(), 1);
    chk("R8 three txb", n_txb, 3);
    chk("R8 multi frame_len", last_len, 13);
    chk("R3 not-ready descriptor unchanged", get_word(32), 32'h28000002);
  endtask

  task automatic t_wrap();
    clear_obs();
    put_desc(32, 16'hA800, 16'd2, 'h400);
    kick_and_wait();
    chk("R6 wrap frame bytes", seg_bad(0, 'h400, 2), 0);
    chk("R5 wrap writeback keeps wrap", get_word(32), 32'h28000002);
    clear_obs();
    put_desc(0, 16'h8800, 16'd1, 'h410);
    kick_and_wait();
    chk("R6 after wrap reads ring start", rx_n, 1);
    chk("R6 after wrap byte", int'(rx_d[0]), int'(pat('h410)));
  endtask

  task automatic t_base();
    clear_obs();
    put_desc('h40, 16'h8800, 16'd4, 'h500);
    put_desc('h48, 16'h0000, 16'd0, 0);
    write_base('h43);
    kick_and_wait();
    chk("R7 aligned ring start byte count", rx_n, 4);
    chk("R7 aligned ring start data", seg_bad(0, 'h500, 4), 0);
    chk("R7 writeback at aligned address", get_word('h40), 32'h08000004);
  endtask

  task automatic t_cap();
    clear_obs();
    put_desc('h80, 16'h8000, 16'd1500, 'h800);
    put_desc('h88, 16'h8000, 16'd1500, 'h800);
    put_desc('h90, 16'h8800, 16'd10, 'h100);
    put_desc('h98, 16'h0000, 16'd0, 0);
    write_base('h80);
    kick_and_wait();
    chk("R9 capped byte count", rx_n, 2032);
    chk("R9 first part data", seg_bad(0, 'h800, 1500), 0);
    chk("R9 clipped part data", seg_bad(1500, 'h800, 532), 0);
    chk("R9 tlast on byte 2032", int'(rx_l[2031]), 1);
    chk("R9 babt pulses", n_babt, 2);
    chk("R9 frame_len capped", last_len, 2032);
    chk("R8 cap txb", n_txb, 3);
    chk("R5 writeback keeps original length", get_word('h88), 32'h000005DC);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    for (int i = 0; i < 4096; i++) begin rx_d[i] = '0; rx_l[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_single();
    t_multi();
    t_wrap();
    t_base();
    t_cap();
    finish_run();
  end
endmodule